// File: doc/BRIEF.md
# Majority-Voting UART with Independent Rate Select

This block is a full-duplex serial port, transmitter and receiver, that takes all of its timing from one master clock. That clock runs at a fixed multiple (64 by default) of a modem's synchronous data rate. The transmit side and the receive side each have their own rate select. A select of 0 runs that side at the data rate. A select of 1 runs it at twice the data rate. Frames are 8N1: one low start bit, eight data bits sent least significant bit first, and one high stop bit.

The receiver does not rely on a single sample per bit. It takes eight evenly spaced samples across each bit period and decides the bit by majority vote. A four-against-four tie counts as logic 1. A start bit is taken only when the vote over its window is low, so short low glitches on an idle line are thrown away. A stop bit that votes low is reported as a framing error, and the byte is still delivered with that error flag.

Both sides use a valid/ready byte interface. A flow-control input holds the transmitter off. A flow-control output tells the far end whether the receive register has room.

Top module: `uart_mv_top`

## Requirements
- R1: After synchronous reset, txd is 1, rx_valid is 0, rx_frame_err is 0 and rx_clear is 1. tx_ready then simply follows tx_allow.
- R2: The transmitter sends 8N1 frames: start bit 0, then tx_data bit 0 first through bit 7, then stop bit 1. Each bit lasts 64 clocks when tx_rate2x=0 and 32 clocks when tx_rate2x=1. txd drops to the start bit on the clock edge that accepts the byte.
- R3: tx_ready is 1 only while no frame is in progress and tx_allow is 1. A byte is taken on a clock edge where tx_valid and tx_ready are both 1.
- R4: While tx_allow is 0, no new frame starts, txd stays 1 and tx_ready stays 0.
- R5: The receiver's bit period is 64 clocks when rx_rate2x=0 and 32 clocks when rx_rate2x=1. In each bit period it takes 8 samples, spaced 8 or 4 clocks apart, and assembles bits least significant first. The receive rate is chosen independently of the transmit rate.
- R6: Each received bit is 1 when at least 4 of its 8 samples are 1, so a 4/4 tie decides 1.
- R7: A low level on rxd whose start-bit window votes 1 (including a tie) is ignored: no byte is delivered.
- R8: When the stop bit votes 0, the byte is delivered with rx_frame_err=1. Otherwise rx_frame_err=0 with the byte.
- R9: rx_valid and rx_data hold until a clock edge with rx_ready=1, which clears rx_valid. rx_clear equals the inverse of rx_valid. A frame that completes while a byte is still held is discarded, and the held byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 64x the data rate |
| rst | input | 1 | Synchronous active-high reset |
| tx_rate2x | input | 1 | Transmit rate select: 0 = data rate, 1 = twice the data rate |
| rx_rate2x | input | 1 | Receive rate select: 0 = data rate, 1 = twice the data rate |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Transmitter takes a byte this cycle if tx_valid is high |
| tx_allow | input | 1 | Flow-control input; 0 holds off new frames |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | rx_data holds an unread byte |
| rx_ready | input | 1 | Consumer takes the held byte |
| rx_frame_err | output | 1 | Held byte's stop bit voted 0 |
| rx_clear | output | 1 | Flow-control output; 1 when the receive register is free |

## Verification
The transmit start bit appears on the edge that accepts the byte. Every later bit boundary follows exactly 64 or 32 clocks after the previous one, so the bench samples txd in the middle of each bit, counted from the accepting edge. Received samples reach the voter after two synchronizer stages, each one a clock, and the vote lands on the last sample of the stop bit. rx_valid therefore rises 638 clocks (1x) or 320 clocks (2x) after the start bit's first edge, which is just before the stop bit ends, and the bench reads the byte once the whole frame has been driven, allowing a bounded wait. The stop-bit and start-bit tie and near-tie cases follow from the sample spacing. With a half-tick phase offset plus the two synchronizer clocks, the samples fall at 4+8k (1x) or 2+4k (2x) clocks into each bit, so a stop bit held low for its first 32 clocks gives a tie and one held low for 40 clocks gives five low samples.

// File: rtl/uart_mv_pkg.sv
package uart_mv_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/uart_mv_div.sv
// Free-running divider: hit pulses on the last count of each period.
module uart_mv_div #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] preset,
  input  logic [W-1:0] lim,
  output logic         hit
);
  logic [W-1:0] cnt;

  assign hit = (cnt == lim - W'(1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= preset;
    else if (hit)  cnt <= '0;
    else           cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/uart_mv_vote.sv
// Majority decision over N samples; a tie resolves to 1.
module uart_mv_vote #(
  parameter int N = 8
) (
  input  logic [N-1:0] win,
  output logic         bit_o
);
  localparam int OW = $clog2(N + 1);
  logic [OW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < N; i++) ones = ones + OW'(win[i]);
  end

  assign bit_o = (ones >= OW'(N / 2));
endmodule

// File: rtl/uart_mv_tx.sv
module uart_mv_tx #(
  parameter int RATE_MUL = 64,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rate2x,
  input  logic          allow,
  input  logic [DW-1:0] data,
  input  logic          valid,
  output logic          ready,
  output logic          txd
);
  localparam int CW   = $clog2(RATE_MUL + 1);
  localparam int IW   = $clog2(DW + 2);
  localparam logic [CW-1:0] BIT1 = CW'(RATE_MUL);
  localparam logic [CW-1:0] BIT2 = CW'(RATE_MUL / 2);
  localparam logic [IW-1:0] LAST = IW'(DW + 1);

  logic          busy;
  logic [DW:0]   sh;
  logic [IW-1:0] idx;
  logic [CW-1:0] lim_q;
  logic          hit;
  logic          accept;

  assign ready  = !busy && allow;
  assign accept = valid && ready;

  uart_mv_div #(.W(CW)) u_div (
    .clk(clk), .rst(rst), .load(accept), .preset('0), .lim(lim_q), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      txd   <= 1'b1;
      sh    <= '1;
      idx   <= '0;
      lim_q <= BIT1;
    end else if (accept) begin
      busy  <= 1'b1;
      txd   <= 1'b0;
      sh    <= {1'b1, data};
      idx   <= '0;
      lim_q <= rate2x ? BIT2 : BIT1;
    end else if (busy && hit) begin
      if (idx == LAST) begin
        busy <= 1'b0;
        txd  <= 1'b1;
      end else begin
        txd <= sh[0];
        sh  <= {1'b1, sh[DW:1]};
        idx <= idx + IW'(1);
      end
    end
  end
endmodule

// File: rtl/uart_mv_rx.sv
module uart_mv_rx
  import uart_mv_pkg::*;
#(
  parameter int RATE_MUL = 64,
  parameter int NS       = 8,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rate2x,
  input  logic          rxd,
  input  logic          ready_in,
  output logic [DW-1:0] data,
  output logic          valid,
  output logic          ferr
);
  localparam int TICK1 = RATE_MUL / NS;
  localparam int TICK2 = TICK1 / 2;
  localparam int TW    = $clog2(TICK1 + 1);
  localparam int SW    = $clog2(NS);
  localparam int DIW   = $clog2(DW);
  localparam logic [SW-1:0]  SLAST = SW'(NS - 1);
  localparam logic [DIW-1:0] DLAST = DIW'(DW - 1);

  logic [1:0]    sync;
  logic          rxs;
  rx_state_t     state;
  logic [NS-2:0] win;
  logic [NS-1:0] win_nx;
  logic [SW-1:0] scnt;
  logic [DIW-1:0] idx;
  logic [DW-1:0] shreg;
  logic [TW-1:0] lim_q;
  logic [TW-1:0] preset;
  logic          hit, load, last, vbit;

  assign rxs    = sync[1];
  assign load   = (state == RX_IDLE) && !rxs;
  assign preset = rate2x ? TW'(TICK2 / 2) : TW'(TICK1 / 2);
  assign win_nx = {win, rxs};
  assign last   = hit && (scnt == SLAST) && (state != RX_IDLE);

  uart_mv_div #(.W(TW)) u_div (
    .clk(clk), .rst(rst), .load(load), .preset(preset), .lim(lim_q), .hit(hit)
  );

  uart_mv_vote #(.N(NS)) u_vote (.win(win_nx), .bit_o(vbit));

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;
      win   <= '1;
      scnt  <= '0;
      idx   <= '0;
      shreg <= '0;
      lim_q <= TW'(TICK1);
      data  <= '0;
      valid <= 1'b0;
      ferr  <= 1'b0;
    end else begin
      if (valid && ready_in) valid <= 1'b0;
      if (state == RX_IDLE) begin
        if (!rxs) begin
          state <= RX_START;
          scnt  <= '0;
          lim_q <= rate2x ? TW'(TICK2) : TW'(TICK1);
        end
      end else if (hit) begin
        win  <= win_nx[NS-2:0];
        scnt <= (scnt == SLAST) ? '0 : scnt + SW'(1);
        if (last) begin
          unique case (state)
            RX_START: begin
              state <= vbit ? RX_IDLE : RX_DATA;
              idx   <= '0;
            end
            RX_DATA: begin
              shreg <= {vbit, shreg[DW-1:1]};
              if (idx == DLAST) state <= RX_STOP;
              else              idx   <= idx + DIW'(1);
            end
            default: begin
              state <= RX_IDLE;
              if (!valid || ready_in) begin
                data  <= shreg;
                ferr  <= !vbit;
                valid <= 1'b1;
              end
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/uart_mv_top.sv
module uart_mv_top #(
  parameter int RATE_MUL   = 64,
  parameter int RX_SAMPLES = 8,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tx_rate2x,
  input  logic                 rx_rate2x,
  input  logic [DATA_BITS-1:0] tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic                 tx_allow,
  output logic                 txd,
  input  logic                 rxd,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic                 rx_frame_err,
  output logic                 rx_clear
);
  uart_mv_tx #(.RATE_MUL(RATE_MUL), .DW(DATA_BITS)) u_tx (
    .clk(clk), .rst(rst), .rate2x(tx_rate2x), .allow(tx_allow),
    .data(tx_data), .valid(tx_valid), .ready(tx_ready), .txd(txd)
  );

  uart_mv_rx #(.RATE_MUL(RATE_MUL), .NS(RX_SAMPLES), .DW(DATA_BITS)) u_rx (
    .clk(clk), .rst(rst), .rate2x(rx_rate2x), .rxd(rxd), .ready_in(rx_ready),
    .data(rx_data), .valid(rx_valid), .ferr(rx_frame_err)
  );

  assign rx_clear = !rx_valid;
endmodule

// File: rtl/uart_mv_checker.sv
module uart_mv_checker #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 tx_valid,
  input logic                 tx_ready,
  input logic                 tx_allow,
  input logic                 txd,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 rx_valid,
  input logic                 rx_ready,
  input logic                 rx_frame_err
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (txd && !rx_valid && !rx_frame_err));
  // R4
  a_r4_hold_off: assert property (@(posedge clk) disable iff (rst) !tx_allow |-> !tx_ready);
  // R2, R3
  a_r2_start_on_accept: assert property (@(posedge clk) disable iff (rst) (tx_valid && tx_ready) |=> !txd);
  // R3
  a_r3_ready_line_idle: assert property (@(posedge clk) disable iff (rst) tx_ready |-> txd);
  // R9
  a_r9_hold_byte: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_frame_err)));
  // R8
  a_r8_err_with_byte: assert property (@(posedge clk) disable iff (rst) $rose(rx_frame_err) |-> rx_valid);
endmodule

bind uart_mv_top uart_mv_checker #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_allow(tx_allow),
  .txd(txd), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_frame_err(rx_frame_err)
);

// File: tb/tb_uart_mv_top.sv
module tb_uart_mv_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 150000;
  localparam int NVEC       = 6;
  // {tx_rate2x, rx_rate2x, byte}
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'hA5}, {1'b1, 1'b1, 8'h3C}, {1'b0, 1'b1, 8'h01},
    {1'b1, 1'b0, 8'h80}, {1'b0, 1'b0, 8'hFF}, {1'b1, 1'b1, 8'h00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_rate2x = 1'b0, rx_rate2x = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_valid = 1'b0, tx_allow = 1'b1, rxd = 1'b1, rx_ready = 1'b0;
  logic tx_ready, txd, rx_valid, rx_frame_err, rx_clear;
  logic [7:0] rx_data;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_mv_top dut (
    .clk(clk), .rst(rst), .tx_rate2x(tx_rate2x), .rx_rate2x(rx_rate2x),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_allow(tx_allow),
    .txd(txd), .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_frame_err(rx_frame_err), .rx_clear(rx_clear)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2: send one byte and sample txd mid-bit from the accepting edge
  task automatic send_tx(input logic [7:0] d, input bit r2);
    int len;
    logic [7:0] got;
    logic st, sp;
    len = r2 ? 32 : 64;
    @(negedge clk);
    tx_rate2x = r2; tx_data = d; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (len / 2 - 1) @(negedge clk);
    st = txd;
    for (int i = 0; i < 8; i++) begin
      repeat (len) @(negedge clk);
      got[i] = txd;
    end
    repeat (len) @(negedge clk);
    sp = txd;
    check(st == 1'b0 && sp == 1'b1, "R2 start/stop", {st, sp}, 2'b01);
    check(got == d, "R2 data", got, d);
    repeat (len / 2 + 2) @(negedge clk);
  endtask

  // R5: drive an 8N1 frame; stop bit low for stop_low clocks first
  task automatic send_rx(input logic [7:0] d, input bit r2, input int stop_low);
    int len;
    len = r2 ? 32 : 64;
    @(negedge clk);
    rx_rate2x = r2;
    rxd = 1'b0;
    repeat (len) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (len) @(negedge clk);
    end
    if (stop_low > 0) begin
      rxd = 1'b0;
      repeat (stop_low) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (len - stop_low) @(negedge clk);
  endtask

  task automatic expect_rx(input logic [7:0] d, input bit fe, input string req);
    int w = 0;
    while (!rx_valid && w < 100) begin
      @(negedge clk); w++;
    end
    check(rx_valid == 1'b1, req, rx_valid, 1);
    check(rx_data == d, req, rx_data, d);
    check(rx_frame_err == fe, req, rx_frame_err, fe);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    check(rx_valid == 1'b0 && rx_clear == 1'b1, "R9 ack clears", {rx_valid, rx_clear}, 2'b01);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(txd == 1'b1 && rx_valid == 1'b0 && rx_frame_err == 1'b0 && rx_clear == 1'b1 && tx_ready == 1'b1,
          "R1 reset state", {txd, rx_valid, rx_frame_err, rx_clear, tx_ready}, 5'b10011);

    // R2, R3, R5, R6: table walk with independent rates
    for (int v = 0; v < NVEC; v++) begin
      send_tx(VEC[v][7:0], VEC[v][9]);
      check(tx_ready == 1'b1, "R3 ready after frame", tx_ready, 1);
      send_rx(VEC[v][7:0], VEC[v][8], 0);
      expect_rx(VEC[v][7:0], 1'b0, "R5 rx byte");
    end

    // R4: hold-off while tx_allow is low
    @(negedge clk);
    tx_allow = 1'b0; tx_data = 8'h96; tx_valid = 1'b1;
    begin
      bit moved = 1'b0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (txd != 1'b1 || tx_ready != 1'b0) moved = 1'b1;
      end
      check(!moved, "R4 hold off", moved, 0);
    end
    tx_valid = 1'b0; tx_allow = 1'b1;
    send_tx(8'h96, 1'b0);

    // R6: stop bit low for 32 of 64 clocks -> 4/4 tie -> 1, no error
    send_rx(8'hC3, 1'b0, 32);
    expect_rx(8'hC3, 1'b0, "R6 tie stop");
    // R8: stop bit low for 40 clocks -> 5 low samples -> framing error
    send_rx(8'h5A, 1'b0, 40);
    expect_rx(8'h5A, 1'b1, "R8 framing error");
    // R8: 2x rate, stop low 20 of 32 -> 5 low samples
    send_rx(8'h69, 1'b1, 20);
    expect_rx(8'h69, 1'b1, "R8 framing error 2x");

    // R7: short glitch at 1x, all samples high
    @(negedge clk);
    rx_rate2x = 1'b0; rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (700) @(negedge clk);
    check(rx_valid == 1'b0, "R7 glitch 1x ignored", rx_valid, 0);
    // R7: 2x, low 15 clocks -> tie in start window -> rejected
    rx_rate2x = 1'b1; rxd = 1'b0;
    repeat (15) @(negedge clk);
    rxd = 1'b1;
    repeat (400) @(negedge clk);
    check(rx_valid == 1'b0, "R7 tie start ignored", rx_valid, 0);
    send_rx(8'hE7, 1'b1, 0);
    expect_rx(8'hE7, 1'b0, "R7 clean frame after glitch");

    // R9: second frame while full is discarded
    send_rx(8'h11, 1'b0, 0);
    send_rx(8'h22, 1'b0, 0);
    repeat (10) @(negedge clk);
    check(rx_clear == 1'b0, "R9 clear low when full", rx_clear, 0);
    expect_rx(8'h11, 1'b0, "R9 held byte kept");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule